// File: doc/BRIEF.md
# STS-N Receive Framer and Line Checker

This block accepts a byte-aligned receive stream carrying an STS-N signal (N = 48 by default) and finds the frame. It does this by searching for the boundary between the framing byte groups. Once frame timing is confirmed, it tracks the nine-row frame and can remove the frame-synchronous scrambling. It checks the section parity byte and adds the parity bit errors to a running total. It also compares a link-identification overhead byte against a configured value.

Downstream logic receives the recovered bytes together with a one-cycle frame pulse and a payload marker. The payload marker is high for every byte outside the transport overhead columns. Out-of-frame and loss-of-frame are reported as levels. While loss-of-frame is active, the data can optionally be forced to all ones as a line alarm indication.

A frame is 9 rows of 90·N bytes, and byte (row 0, column 0) is the first framing byte. Every output is registered. A received byte appears on `out_data` two clock cycles after it is presented on `rx_data`.

Top module: `sts_rx_framer`

## Requirements
- R1: After reset `oof` is 1. In the hunt state, a byte 0xF6 followed directly by a byte 0x28 (the last first-framing byte and the first second-framing byte, at row 0 column N) fixes the frame timing. `oof` falls only when the same pair is also found at that position in the next frame.
- R2: While in frame, the 0xF6/0x28 pair is checked once per frame. `oof` rises after BAD_LIMIT (4) consecutive frames fail the check. A frame that passes the check restarts the failure count.
- R3: `lof` rises after `oof` has been continuously high for LOF_FRAMES (24) frame lengths. It falls after `oof` has been continuously low for the same length.
- R4: With `cfg_descram_en` = 1, every byte except the first 3·N bytes of row 0 is XORed with the x^7+x^6+1 sequence. The sequence is restarted from all ones at row 0 column 3·N and its first output bit is the byte MSB. With the enable at 0, bytes pass through unchanged.
- R5: When `cfg_b1_en` = 1 and the whole previous frame was tracked, the descrambled byte at row 1 column 0 is compared with the bitwise XOR of all received (scrambled) bytes of the previous frame. The count of differing bits is added to `b1_err_count`. With `cfg_b1_en` = 0 the count does not change.
- R6: `b1_err_count` saturates at 2^CNT_W−1 and returns to 0 on reset.
- R7: While in frame, the byte at row 0 column 2·N is compared with `cfg_link_id` once per frame, and `link_mismatch` holds the result. `link_mismatch` is 0 while `oof` is 1.
- R8: Outside the hunt state, `out_spe` is 1 exactly for bytes at column 3·N or higher in every row. It is 0 for overhead bytes.
- R9: Outside the hunt state, `out_frame` is a one-cycle pulse that accompanies the byte at row 0 column 0 on `out_data`.
- R10: With `cfg_ais_en` = 1 and `lof` = 1, `out_data` is 0xFF. With `cfg_ais_en` = 0 the recovered data is passed through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Byte-aligned received stream |
| cfg_descram_en | input | 1 | Enable frame-synchronous descrambling |
| cfg_b1_en | input | 1 | Enable section parity checking |
| cfg_ais_en | input | 1 | Force all ones while loss-of-frame |
| cfg_link_id | input | 8 | Expected link-identification byte |
| out_data | output | 8 | Recovered byte |
| out_frame | output | 1 | Pulse with the first byte of a frame |
| out_spe | output | 1 | Payload byte marker |
| oof | output | 1 | Out-of-frame |
| lof | output | 1 | Loss-of-frame |
| link_mismatch | output | 1 | Link-identification byte differs from expected |
| b1_err_count | output | CNT_W | Saturating parity bit-error total |

## Verification
If the internal row/column counter were wrong, `out_frame` and `out_spe` would shift against the data in the very next frame. The framing check would also start failing, so `oof` would rise after four frames. A descrambler seeded at the wrong column corrupts every payload byte of the first frame in which it is enabled. A parity accumulator that missed a byte adds a non-zero bit count at row 1 of the following frame, which is one frame of delay. A faulty loss-of-frame integrator would show up only on the 24-frame scale, so the bench samples `lof` on both sides of that window, both while it is rising and while it is clearing.

// File: rtl/stsrx_pkg.sv
package stsrx_pkg;

  localparam logic [7:0] A1_BYTE = 8'hF6;
  localparam logic [7:0] A2_BYTE = 8'h28;

  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_PRESYNC = 2'd1,
    ST_SYNC    = 2'd2
  } align_state_t;

  // Eight sequence bits, MSB first, from the x^7+x^6+1 generator
  function automatic logic [7:0] scr_byte(input logic [6:0] seed);
    logic [6:0] s;
    logic [7:0] r;
    s = seed;
    for (int i = 7; i >= 0; i--) begin
      r[i] = s[6];
      s = {s[5:0], s[6] ^ s[5]};
    end
    return r;
  endfunction

  // Generator state after eight steps
  function automatic logic [6:0] scr_next(input logic [6:0] seed);
    logic [6:0] s;
    s = seed;
    for (int i = 0; i < 8; i++) begin
      s = {s[5:0], s[6] ^ s[5]};
    end
    return s;
  endfunction

  function automatic logic [3:0] pop8(input logic [7:0] v);
    logic [3:0] n;
    n = 4'd0;
    for (int i = 0; i < 8; i++) begin
      n = n + {3'd0, v[i]};
    end
    return n;
  endfunction

endpackage

// File: rtl/stsrx_align.sv
module stsrx_align
  import stsrx_pkg::*;
#(
  parameter int STS_N      = 48,
  parameter int BAD_LIMIT  = 4,
  parameter int LOF_FRAMES = 24,
  parameter int COL_W      = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       rx_byte,
  output logic [7:0]       byte_q,
  output logic [3:0]       row_q,
  output logic [COL_W-1:0] col_q,
  output logic             hunting,
  output logic             oof,
  output logic             lof
);

  localparam int COLS      = 90 * STS_N;
  localparam int LOF_LIMIT = LOF_FRAMES * 9 * COLS;
  localparam int LOF_W     = $clog2(LOF_LIMIT + 1);
  localparam int BAD_W     = $clog2(BAD_LIMIT + 1);
  localparam logic [COL_W-1:0] LAST_COL   = COL_W'(COLS - 1);
  localparam logic [COL_W-1:0] A2_COL     = COL_W'(STS_N);
  localparam logic [COL_W-1:0] RESUME_COL = COL_W'(STS_N + 1);

  align_state_t     state_q;
  logic [7:0]       prev_q;
  logic [BAD_W-1:0] bad_q;
  logic [LOF_W-1:0] lof_cnt_q;
  logic             pat_ok;
  logic             at_a2;

  assign pat_ok  = (prev_q == A1_BYTE) && (byte_q == A2_BYTE);
  assign at_a2   = (row_q == 4'd0) && (col_q == A2_COL);
  assign hunting = (state_q == ST_HUNT);
  assign oof     = (state_q != ST_SYNC);

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_q <= '0;
      prev_q <= '0;
    end else begin
      byte_q <= rx_byte;
      prev_q <= byte_q;
    end
  end

  // Position of the byte held in byte_q
  always_ff @(posedge clk) begin
    if (rst) begin
      row_q <= '0;
      col_q <= '0;
    end else if (hunting && pat_ok) begin
      row_q <= 4'd0;
      col_q <= RESUME_COL;
    end else if (col_q == LAST_COL) begin
      col_q <= '0;
      row_q <= (row_q == 4'd8) ? 4'd0 : row_q + 4'd1;
    end else begin
      col_q <= col_q + COL_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_HUNT;
      bad_q   <= '0;
    end else begin
      case (state_q)
        ST_HUNT: begin
          if (pat_ok) begin
            state_q <= ST_PRESYNC;
            bad_q   <= '0;
          end
        end
        ST_PRESYNC: begin
          if (at_a2) state_q <= pat_ok ? ST_SYNC : ST_HUNT;
        end
        ST_SYNC: begin
          if (at_a2) begin
            if (pat_ok) begin
              bad_q <= '0;
            end else if (bad_q == BAD_W'(BAD_LIMIT - 1)) begin
              state_q <= ST_HUNT;
              bad_q   <= '0;
            end else begin
              bad_q <= bad_q + BAD_W'(1);
            end
          end
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end

  // Integrate disagreement between oof and lof over a fixed byte window
  always_ff @(posedge clk) begin
    if (rst) begin
      lof       <= 1'b0;
      lof_cnt_q <= '0;
    end else if (oof != lof) begin
      if (lof_cnt_q == LOF_W'(LOF_LIMIT - 1)) begin
        lof       <= ~lof;
        lof_cnt_q <= '0;
      end else begin
        lof_cnt_q <= lof_cnt_q + LOF_W'(1);
      end
    end else begin
      lof_cnt_q <= '0;
    end
  end

  AST_LOF_RISES_IN_OOF: assert property (@(posedge clk) disable iff (rst)
    $rose(lof) |-> $past(oof)); // R3
  AST_LOF_FALLS_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    $fell(lof) |-> !$past(oof)); // R3
  AST_SYNC_VIA_PRESYNC: assert property (@(posedge clk) disable iff (rst)
    $fell(oof) |-> $past(state_q == ST_PRESYNC)); // R1
  AST_POS_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    (row_q < 4'd9) && (col_q <= LAST_COL)); // R9

endmodule

// File: rtl/stsrx_descram.sv
module stsrx_descram
  import stsrx_pkg::*;
#(
  parameter int STS_N = 48,
  parameter int COL_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [7:0]       byte_i,
  input  logic [3:0]       row_i,
  input  logic [COL_W-1:0] col_i,
  output logic [7:0]       byte_o
);

  localparam logic [COL_W-1:0] SEED_COL = COL_W'(3 * STS_N - 1);
  localparam logic [COL_W-1:0] OH_COLS  = COL_W'(3 * STS_N);

  logic [6:0] lfsr_q;
  logic       bypass;

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr_q <= 7'h7F;
    end else if ((row_i == 4'd0) && (col_i == SEED_COL)) begin
      lfsr_q <= 7'h7F;
    end else begin
      lfsr_q <= scr_next(lfsr_q);
    end
  end

  assign bypass = (row_i == 4'd0) && (col_i < OH_COLS);
  assign byte_o = (enable && !bypass) ? (byte_i ^ scr_byte(lfsr_q)) : byte_i;

endmodule

// File: rtl/stsrx_bip.sv
module stsrx_bip
  import stsrx_pkg::*;
#(
  parameter int STS_N = 48,
  parameter int COL_W = 13,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             tracking,
  input  logic [7:0]       raw_i,
  input  logic [7:0]       desc_i,
  input  logic [3:0]       row_i,
  input  logic [COL_W-1:0] col_i,
  output logic [CNT_W-1:0] err_cnt
);

  localparam logic [COL_W-1:0] LAST_COL = COL_W'(90 * STS_N - 1);

  logic [7:0]     acc_q;
  logic [7:0]     bip_prev_q;
  logic           full_q;
  logic           valid_q;
  logic           frame_end;
  logic           at_b1;
  logic [CNT_W:0] sum;

  assign frame_end = (row_i == 4'd8) && (col_i == LAST_COL);
  assign at_b1     = (row_i == 4'd1) && (col_i == '0);
  assign sum       = {1'b0, err_cnt} + (CNT_W + 1)'(pop8(desc_i ^ bip_prev_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q      <= '0;
      bip_prev_q <= '0;
      full_q     <= 1'b0;
      valid_q    <= 1'b0;
    end else begin
      if (frame_end) begin
        acc_q      <= '0;
        bip_prev_q <= acc_q ^ raw_i;
        valid_q    <= full_q;
      end else begin
        acc_q <= acc_q ^ raw_i;
      end
      if (!tracking) begin
        full_q  <= 1'b0;
        valid_q <= 1'b0;
      end else if ((row_i == 4'd0) && (col_i == '0)) begin
        full_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_cnt <= '0;
    end else if (enable && valid_q && tracking && at_b1) begin
      err_cnt <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    end
  end

  AST_COUNT_NEVER_DROPS: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (err_cnt >= $past(err_cnt))); // R6
  AST_COUNT_ONLY_AT_B1: assert property (@(posedge clk) disable iff (rst)
    !(at_b1 && enable) |=> $stable(err_cnt)); // R5

endmodule

// File: rtl/sts_rx_framer.sv
module sts_rx_framer
  import stsrx_pkg::*;
#(
  parameter int STS_N      = 48,
  parameter int LOF_FRAMES = 24,
  parameter int BAD_LIMIT  = 4,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       rx_data,
  input  logic             cfg_descram_en,
  input  logic             cfg_b1_en,
  input  logic             cfg_ais_en,
  input  logic [7:0]       cfg_link_id,
  output logic [7:0]       out_data,
  output logic             out_frame,
  output logic             out_spe,
  output logic             oof,
  output logic             lof,
  output logic             link_mismatch,
  output logic [CNT_W-1:0] b1_err_count
);

  localparam int COL_W = $clog2(90 * STS_N);
  localparam logic [COL_W-1:0] LINK_COL = COL_W'(2 * STS_N);
  localparam logic [COL_W-1:0] SPE_COL  = COL_W'(3 * STS_N);

  logic [7:0]       byte_q;
  logic [7:0]       desc_byte;
  logic [3:0]       row_q;
  logic [COL_W-1:0] col_q;
  logic             hunting;

  stsrx_align #(
    .STS_N(STS_N), .BAD_LIMIT(BAD_LIMIT), .LOF_FRAMES(LOF_FRAMES), .COL_W(COL_W)
  ) align_i (
    .clk(clk), .rst(rst), .rx_byte(rx_data), .byte_q(byte_q),
    .row_q(row_q), .col_q(col_q), .hunting(hunting), .oof(oof), .lof(lof)
  );

  stsrx_descram #(.STS_N(STS_N), .COL_W(COL_W)) descram_i (
    .clk(clk), .rst(rst), .enable(cfg_descram_en), .byte_i(byte_q),
    .row_i(row_q), .col_i(col_q), .byte_o(desc_byte)
  );

  stsrx_bip #(.STS_N(STS_N), .COL_W(COL_W), .CNT_W(CNT_W)) bip_i (
    .clk(clk), .rst(rst), .enable(cfg_b1_en), .tracking(!hunting),
    .raw_i(byte_q), .desc_i(desc_byte), .row_i(row_q), .col_i(col_q),
    .err_cnt(b1_err_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data  <= '0;
      out_frame <= 1'b0;
      out_spe   <= 1'b0;
    end else begin
      out_data  <= (cfg_ais_en && lof) ? 8'hFF : desc_byte;
      out_frame <= !hunting && (row_q == 4'd0) && (col_q == '0);
      out_spe   <= !hunting && (col_q >= SPE_COL);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      link_mismatch <= 1'b0;
    end else if (oof) begin
      link_mismatch <= 1'b0;
    end else if ((row_q == 4'd0) && (col_q == LINK_COL)) begin
      link_mismatch <= (byte_q != cfg_link_id);
    end
  end

  AST_AIS_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
    (cfg_ais_en && lof) |=> (out_data == 8'hFF)); // R10
  AST_NO_SPE_ON_PULSE: assert property (@(posedge clk) disable iff (rst)
    out_frame |-> !out_spe); // R8
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    out_frame |=> !out_frame); // R9
  AST_LINK_QUIET_IN_OOF: assert property (@(posedge clk) disable iff (rst)
    $past(oof) |-> !link_mismatch); // R7

endmodule

// File: tb/sts_rx_framer_tb_top.sv
`timescale 1ns/1ps
module sts_rx_framer_tb_top;

  localparam int N     = 1;
  localparam int COLS  = 90 * N;
  localparam int CNT_W = 6;

  typedef struct packed {
    int         nf;
    bit         bad;
    bit         scr;
    logic [7:0] mask;
    logic [7:0] link;
    bit         chk;
    bit         exp_oof;
    int         exp_b1d;
    bit         exp_lm;
  } row_t;

  localparam int NROWS = 11;
  localparam row_t TBL [NROWS] = '{
    '{3, 1'b0, 1'b0, 8'h00, 8'h5A, 1'b1, 1'b0, 0, 1'b0},
    '{2, 1'b0, 1'b1, 8'h00, 8'h5A, 1'b1, 1'b0, 0, 1'b0},
    '{1, 1'b0, 1'b1, 8'h81, 8'h5A, 1'b1, 1'b0, 2, 1'b0},
    '{1, 1'b0, 1'b1, 8'h00, 8'h33, 1'b1, 1'b0, 0, 1'b1},
    '{1, 1'b0, 1'b0, 8'h00, 8'h5A, 1'b1, 1'b0, 0, 1'b0},
    '{2, 1'b0, 1'b0, 8'h0F, 8'h5A, 1'b1, 1'b0, 8, 1'b0},
    '{3, 1'b1, 1'b0, 8'h00, 8'h5A, 1'b1, 1'b0, 0, 1'b0},
    '{1, 1'b0, 1'b0, 8'h00, 8'h5A, 1'b1, 1'b0, 0, 1'b0},
    '{3, 1'b1, 1'b0, 8'h00, 8'h5A, 1'b1, 1'b0, 0, 1'b0},
    '{1, 1'b1, 1'b0, 8'h00, 8'h5A, 1'b0, 1'b1, 0, 1'b0},
    '{2, 1'b0, 1'b0, 8'h00, 8'h5A, 1'b0, 1'b0, 0, 1'b0}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [7:0]       rx_data = 8'h00;
  logic             cfg_descram_en = 1'b0;
  logic             cfg_b1_en = 1'b1;
  logic             cfg_ais_en = 1'b0;
  logic [7:0]       cfg_link_id = 8'h5A;
  logic [7:0]       out_data;
  logic             out_frame, out_spe, oof, lof, link_mismatch;
  logic [CNT_W-1:0] b1_err_count;

  always #4 clk = ~clk;

  sts_rx_framer #(.STS_N(N), .LOF_FRAMES(24), .BAD_LIMIT(4), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .rx_data(rx_data), .cfg_descram_en(cfg_descram_en),
    .cfg_b1_en(cfg_b1_en), .cfg_ais_en(cfg_ais_en), .cfg_link_id(cfg_link_id),
    .out_data(out_data), .out_frame(out_frame), .out_spe(out_spe), .oof(oof),
    .lof(lof), .link_mismatch(link_mismatch), .b1_err_count(b1_err_count)
  );

  int checks = 0;
  int failures = 0;
  int frame_no = 0;
  logic [6:0] bl = 7'h7F;
  logic [7:0] bip_acc = 8'h00;
  logic [7:0] bip_prev = 8'h00;
  logic [7:0] p1_d = 0, p2_d = 0;
  logic       p1_s = 0, p2_s = 0, p1_f = 0, p2_f = 0, p1_c = 0, p2_c = 0;
  int ed, es, ef, ea, ncmp;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_frame(input bit bad, input bit scr, input logic [7:0] mask,
                            input logic [7:0] link, input bit chk);
    logic [7:0] plain, key, tx;
    ed = 0; es = 0; ef = 0; ea = 0; ncmp = 0;
    for (int r = 0; r < 9; r++) begin
      for (int c = 0; c < COLS; c++) begin
        @(negedge clk);
        if (p2_c) begin
          ncmp++;
          if (out_data != p2_d) ed++;
          if (out_spe != p2_s) es++;
          if (out_frame != p2_f) ef++;
        end
        if (out_data != 8'hFF) ea++;
        if (r == 0 && c < N) plain = 8'hF6;
        else if (r == 0 && c < 2 * N) plain = bad ? 8'h00 : 8'h28;
        else if (r == 0 && c == 2 * N) plain = link;
        else if (r == 1 && c == 0) plain = bip_prev ^ mask;
        else plain = 8'((r * 90 + c + frame_no) & 8'h3F);
        tx = plain;
        if (!(r == 0 && c < 3 * N)) begin
          if (r == 0 && c == 3 * N) bl = 7'h7F;
          for (int i = 7; i >= 0; i--) begin
            key[i] = bl[6];
            bl = {bl[5:0], bl[6] ^ bl[5]};
          end
          if (scr) tx = plain ^ key;
        end
        bip_acc = bip_acc ^ tx;
        if (r == 8 && c == COLS - 1) begin
          bip_prev = bip_acc;
          bip_acc = 8'h00;
        end
        rx_data = tx;
        if (r == 0 && c == 1) cfg_descram_en = scr;
        p2_d = p1_d; p2_s = p1_s; p2_f = p1_f; p2_c = p1_c;
        p1_d = plain; p1_s = (c >= 3 * N); p1_f = (r == 0 && c == 0); p1_c = chk;
      end
    end
    frame_no++;
  endtask

  task automatic frame_report();
    if (ncmp > 0) begin
      check(ed == 0, "R4 data bytes wrong", ed, 0);
      check(es == 0, "R8 payload marker wrong", es, 0);
      check(ef == 0, "R9 frame pulse wrong", ef, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int prev_cnt;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // reset state
    check(oof == 1'b1, "R1 oof after reset", oof, 1);
    check(lof == 1'b0, "R3 lof after reset", lof, 0);
    check(b1_err_count == 0, "R6 count after reset", b1_err_count, 0);
    check(link_mismatch == 1'b0, "R7 link flag after reset", link_mismatch, 0);
    check(out_frame == 1'b0 && out_spe == 1'b0, "R8 markers after reset",
          {out_frame, out_spe}, 0);

    // table walk
    for (int t = 0; t < NROWS; t++) begin
      prev_cnt = int'(b1_err_count);
      for (int f = 0; f < TBL[t].nf; f++) begin
        send_frame(TBL[t].bad, TBL[t].scr, TBL[t].mask, TBL[t].link,
                   TBL[t].chk && !(t == 0 && f == 0));
        frame_report();
      end
      check(oof == TBL[t].exp_oof, $sformatf("R1 R2 oof row %0d", t), oof, TBL[t].exp_oof);
      check(int'(b1_err_count) - prev_cnt == TBL[t].exp_b1d,
            $sformatf("R5 parity delta row %0d", t),
            int'(b1_err_count) - prev_cnt, TBL[t].exp_b1d);
      check(link_mismatch == TBL[t].exp_lm, $sformatf("R7 link row %0d", t),
            link_mismatch, TBL[t].exp_lm);
    end

    // R5: parity check disabled leaves the count unchanged
    send_frame(0, 0, 8'h00, 8'h5A, 1'b1); frame_report();
    send_frame(0, 0, 8'h00, 8'h5A, 1'b1); frame_report();
    prev_cnt = int'(b1_err_count);
    cfg_b1_en = 1'b0;
    send_frame(0, 0, 8'hFF, 8'h5A, 1'b1); frame_report();
    check(int'(b1_err_count) == prev_cnt, "R5 disabled count", b1_err_count, prev_cnt);
    cfg_b1_en = 1'b1;

    // R6: saturation
    for (int f = 0; f < 7; f++) begin
      send_frame(0, 0, 8'hFF, 8'h5A, 1'b1);
    end
    check(b1_err_count == 6'd63, "R6 saturated", b1_err_count, 63);
    send_frame(0, 0, 8'hFF, 8'h5A, 1'b1);
    check(b1_err_count == 6'd63, "R6 held at max", b1_err_count, 63);

    // R3 / R10: loss-of-frame integration and alarm forcing
    cfg_ais_en = 1'b1;
    for (int f = 0; f < 26; f++) send_frame(1, 0, 8'h00, 8'h5A, 1'b0);
    check(oof == 1'b1, "R2 oof during bad framing", oof, 1);
    check(lof == 1'b0, "R3 lof before window", lof, 0);
    for (int f = 0; f < 3; f++) send_frame(1, 0, 8'h00, 8'h5A, 1'b0);
    check(lof == 1'b1, "R3 lof after window", lof, 1);
    send_frame(1, 0, 8'h00, 8'h5A, 1'b0);
    check(ea == 0, "R10 non-ones bytes with alarm on", ea, 0);
    cfg_ais_en = 1'b0;
    send_frame(1, 0, 8'h00, 8'h5A, 1'b0);
    check(ea > 700, "R10 data passes with alarm off", ea, 700);
    for (int f = 0; f < 10; f++) send_frame(0, 0, 8'h00, 8'h5A, 1'b0);
    check(oof == 1'b0, "R1 reacquired", oof, 0);
    check(lof == 1'b1, "R3 lof held while integrating", lof, 1);
    for (int f = 0; f < 17; f++) send_frame(0, 0, 8'h00, 8'h5A, 1'b0);
    check(lof == 1'b0, "R3 lof cleared", lof, 0);

    // reset in service
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(oof == 1'b1, "R1 oof after mid-run reset", oof, 1);
    check(b1_err_count == 0, "R6 count cleared by reset", b1_err_count, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule